// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block takes parallel audio samples and turns them into a single serial data line with a matching frame-sync output. It supports four framings: two-channel I2S, two-channel left-justified, TDM with the sync one bit ahead of the data, and TDM with the sync aligned to the data. TDM frames carry 1 to 8 slots. An external divider supplies `bit_tick`, a one-cycle strobe for each bit period. Every shift, slot change and frame-sync change happens on a cycle in which `bit_tick` is high.

Samples arrive right-justified on a valid/ready handshake, one word per slot in slot order. A single holding register sits between the handshake and the serializer. If that register is empty when a slot starts, the slot is filled with zero or with the word last sent in that slot, and an underrun flag for the slot pulses. Mono mode sends each even slot's word again in the following odd slot. Software gives a configuration word and separate enable and disable strobes. `running` shows whether the transmitter is active. A disable lets the current frame finish.

Top module: `atx_serial_tx`

## Requirements
- R1: After reset, `running`, `sdata`, `fsync` and `uflow` are 0 and `s_ready` is 1.
- R2: The format field is `cfg_i[1:0]`. I2S is 0: `fsync` is low for the left slot (slot 0) and high for the right slot, and it changes one bit before the slot's MSB. Left-justified is 1: `fsync` is high for the left slot, and it changes on the same bit as the MSB.
- R3: Format 2 is TDM with the sync leading the data by one bit. Format 3 is TDM with the sync aligned to the data. The slot count is `cfg_i[8:6]`+1. The sync pulse width is set by `cfg_i[10:9]`: 0 gives one slot, 1 gives half a frame, and 2 or 3 give one bit.
- R4: The length code is `cfg_i[4:2]` and maps as follows: 0 is 32 bits, 1 is 24, 2 is 20, 3 is 18, 4 and 5 are 16, and 6 and 7 are 8 bits. The slot is as wide as the sample, except for codes 1 to 3. For those codes the slot is 32 bits when `cfg_i[5]` is 0 and 24 bits when it is 1. Samples go out MSB first, and the rest of the slot is zero.
- R5: When `cfg_i[11]` (mono) is 1, each odd slot repeats the word sent in the slot just before it, and no input word is taken for the odd slot.
- R6: When a slot starts with no word held, the slot carries zero if `cfg_i[12]` is 0. If `cfg_i[12]` is 1, the slot carries the word last sent in that slot. In both cases `uflow[slot]` pulses for one cycle.
- R7: An `en_stb` pulse while the block is stopped raises `running` on the next cycle. A `dis_stb` pulse lets the current frame finish. `running` falls on the tick that ends that frame.
- R8: The configuration is captured only on an accepted enable. Changes to `cfg_i` while the block is running have no effect on the output.
- R9: Words are taken in arrival order, one per slot start. `s_ready` is low while a word is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per serial bit period |
| cfg_i | input | 13 | Configuration word (fields listed in R2 to R6) |
| en_stb | input | 1 | Enable strobe |
| dis_stb | input | 1 | Disable strobe |
| s_valid | input | 1 | Sample word valid |
| s_ready | output | 1 | Holding register free |
| s_data | input | 32 | Right-justified sample word |
| sdata | output | 1 | Serial data, MSB first |
| fsync | output | 1 | Frame sync |
| running | output | 1 | Transmitter active |
| uflow | output | NSLOT_MAX | Per-slot underrun pulse |

## Verification
The bench keeps the default `NSLOT_MAX` of 8. With that value it can send a full eight-slot TDM frame of 32-bit slots, which is 256 bits, and check the one-bit sync at the wrap point of the frame. It also runs two-, three- and four-slot frames. Together these cover all four framings, the 8-, 16-, 18-, 20-, 24- and 32-bit lengths, both slot-width choices, all three sync widths, mono copying, and both underrun fills against a per-slot model of the last word sent.

// File: rtl/atx_pkg.sv
package atx_pkg;

  localparam int SAMPLE_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_START, ST_RUN} atx_state_e;

  // Field order fixes bit positions: fmt sits in bits [1:0].
  typedef struct packed {
    logic       fill_prev;
    logic       mono;
    logic [1:0] fs_mode;
    logic [2:0] slots_m1;
    logic       slot24;
    logic [2:0] len_code;
    logic [1:0] fmt;
  } atx_cfg_t;

  localparam int CFG_W = $bits(atx_cfg_t);

  function automatic logic [5:0] sample_len(input logic [2:0] code);
    case (code)
      3'd0:        return 6'd32;
      3'd1:        return 6'd24;
      3'd2:        return 6'd20;
      3'd3:        return 6'd18;
      3'd4, 3'd5:  return 6'd16;
      default:     return 6'd8;
    endcase
  endfunction

  function automatic logic [5:0] slot_len(input logic [2:0] code, input logic s24);
    case (code)
      3'd0:              return 6'd32;
      3'd1, 3'd2, 3'd3:  return s24 ? 6'd24 : 6'd32;
      3'd4, 3'd5:        return 6'd16;
      default:           return 6'd8;
    endcase
  endfunction

endpackage

// File: rtl/atx_fsync_gen.sv
module atx_fsync_gen #(
  parameter int PW = 9
) (
  input  logic          active,
  input  logic [1:0]    fmt,
  input  logic [1:0]    fs_mode,
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] frame_len,
  input  logic [5:0]    slot_w,
  output logic          fsync
);
  logic [PW-1:0] q, half, pulse_w;
  logic          lvl;

  always_comb begin
    half = frame_len >> 1;
    // formats 0 and 2 lead the data by one bit: look one position ahead
    if (!fmt[0])
      q = (pos == frame_len - PW'(1)) ? '0 : pos + PW'(1);
    else
      q = pos;
    case (fs_mode)
      2'd0:    pulse_w = PW'(slot_w);
      2'd1:    pulse_w = half;
      default: pulse_w = PW'(1);
    endcase
    if (fmt[1])      lvl = (q < pulse_w);
    else if (fmt[0]) lvl = (q < half);
    else             lvl = (q >= half);
    fsync = active & lvl;
  end
endmodule

// File: rtl/atx_slot_feed.sv
module atx_slot_feed #(
  parameter int NSLOT = 8,
  parameter int DW    = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [DW-1:0]        s_data,
  input  logic                 load,
  input  logic [$clog2(NSLOT)-1:0] slot,
  input  logic                 mono,
  input  logic                 fill_prev,
  output logic [DW-1:0]        word,
  output logic [NSLOT-1:0]     uflow
);
  localparam int IW = $clog2(NSLOT);

  logic [DW-1:0]    hold_q, hold_d;
  logic             full_q, full_d;
  logic [DW-1:0]    last_q [NSLOT];
  logic [NSLOT-1:0] uflow_q, uflow_d;
  logic             odd_copy, take, starve;
  logic [IW-1:0]    prev_idx;

  always_comb begin
    odd_copy = mono & slot[0];
    take     = load & ~odd_copy & full_q;
    starve   = load & ~odd_copy & ~full_q;
    prev_idx = slot & ~IW'(1);
    if (odd_copy)       word = last_q[prev_idx];
    else if (full_q)    word = hold_q;
    else if (fill_prev) word = last_q[slot];
    else                word = '0;
    full_d = full_q;
    hold_d = hold_q;
    if (take) full_d = 1'b0;
    if (s_valid && !full_q) begin
      full_d = 1'b1;
      hold_d = s_data;
    end
    uflow_d = starve ? (NSLOT'(1) << slot) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      full_q  <= 1'b0;
      uflow_q <= '0;
    end else begin
      hold_q  <= hold_d;
      full_q  <= full_d;
      uflow_q <= uflow_d;
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_last
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  last_q[i] <= '0;
      else if (load && slot == i)  last_q[i] <= word;
    end
  end

  assign s_ready = ~full_q;
  assign uflow   = uflow_q;
endmodule

// File: rtl/atx_serial_tx.sv
module atx_serial_tx
  import atx_pkg::*;
#(
  parameter int NSLOT_MAX = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_tick,
  input  logic [12:0]          cfg_i,
  input  logic                 en_stb,
  input  logic                 dis_stb,
  input  logic                 s_valid,
  output logic                 s_ready,
  input  logic [31:0]          s_data,
  output logic                 sdata,
  output logic                 fsync,
  output logic                 running,
  output logic [NSLOT_MAX-1:0] uflow
);
  localparam int DW = SAMPLE_W;
  localparam int IW = $clog2(NSLOT_MAX);
  localparam int PW = $clog2(NSLOT_MAX * DW) + 1;

  atx_state_e    st_q, st_d;
  atx_cfg_t      cfg_q, cfg_d;
  logic          stop_q, stop_d;
  logic [PW-1:0] pos_q, pos_d;
  logic [5:0]    bit_q, bit_d;
  logic [IW-1:0] slot_q, slot_d, ld_slot;
  logic [DW-1:0] sh_q, sh_d, feed_word;
  logic          load, slot_end, frame_end;
  logic [5:0]    slen, swid, lsh;
  logic [IW-1:0] ns_m1;
  logic [PW-1:0] frame_len;

  always_comb begin
    slen      = sample_len(cfg_q.len_code);
    swid      = slot_len(cfg_q.len_code, cfg_q.slot24);
    lsh       = 6'(DW) - slen;
    ns_m1     = cfg_q.fmt[1] ? IW'(cfg_q.slots_m1) : IW'(1);
    frame_len = (PW'(ns_m1) + PW'(1)) * PW'(swid);
    slot_end  = (bit_q == swid - 6'd1);
    frame_end = slot_end && (slot_q == ns_m1);
  end

  always_comb begin
    st_d    = st_q;
    cfg_d   = cfg_q;
    stop_d  = stop_q;
    pos_d   = pos_q;
    bit_d   = bit_q;
    slot_d  = slot_q;
    sh_d    = sh_q;
    load    = 1'b0;
    ld_slot = slot_q;
    case (st_q)
      ST_IDLE: if (en_stb) begin
        st_d   = ST_START;
        cfg_d  = atx_cfg_t'(cfg_i);
        stop_d = 1'b0;
      end
      ST_START: begin
        if (dis_stb) stop_d = 1'b1;
        if (bit_tick) begin
          st_d    = ST_RUN;
          load    = 1'b1;
          ld_slot = '0;
          pos_d   = '0;
          bit_d   = '0;
          slot_d  = '0;
        end
      end
      ST_RUN: begin
        if (dis_stb) stop_d = 1'b1;
        if (bit_tick) begin
          if (frame_end && stop_q) begin
            st_d = ST_IDLE;
          end else if (slot_end) begin
            load    = 1'b1;
            ld_slot = frame_end ? '0 : slot_q + IW'(1);
            slot_d  = ld_slot;
            bit_d   = '0;
            pos_d   = frame_end ? '0 : pos_q + PW'(1);
          end else begin
            bit_d = bit_q + 6'd1;
            pos_d = pos_q + PW'(1);
            sh_d  = {sh_q[DW-2:0], 1'b0};
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    if (load) sh_d = feed_word << lsh;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cfg_q  <= '0;
      stop_q <= 1'b0;
      pos_q  <= '0;
      bit_q  <= '0;
      slot_q <= '0;
      sh_q   <= '0;
    end else begin
      st_q   <= st_d;
      cfg_q  <= cfg_d;
      stop_q <= stop_d;
      pos_q  <= pos_d;
      bit_q  <= bit_d;
      slot_q <= slot_d;
      sh_q   <= sh_d;
    end
  end

  atx_slot_feed #(.NSLOT(NSLOT_MAX), .DW(DW)) i_feed (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .s_ready   (s_ready),
    .s_data    (s_data),
    .load      (load),
    .slot      (ld_slot),
    .mono      (cfg_q.mono),
    .fill_prev (cfg_q.fill_prev),
    .word      (feed_word),
    .uflow     (uflow)
  );

  atx_fsync_gen #(.PW(PW)) i_fsync (
    .active    (st_q == ST_RUN),
    .fmt       (cfg_q.fmt),
    .fs_mode   (cfg_q.fs_mode),
    .pos       (pos_q),
    .frame_len (frame_len),
    .slot_w    (swid),
    .fsync     (fsync)
  );

  assign sdata   = (st_q == ST_RUN) & sh_q[DW-1];
  assign running = (st_q != ST_IDLE);
endmodule

// File: rtl/atx_serial_tx_chk.sv
module atx_serial_tx_chk #(
  parameter int NSLOT_MAX = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 bit_tick,
  input logic                 en_stb,
  input logic                 running,
  input logic                 sdata,
  input logic                 fsync,
  input logic [NSLOT_MAX-1:0] uflow
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!sdata && !fsync));
  // R2
  line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_tick) |-> ($stable(sdata) && $stable(fsync)));
  // R6
  uflow_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(uflow));
  // R6
  uflow_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|uflow) |-> $past(bit_tick));
  // R7
  en_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_stb && !running) |=> running);
  // R7
  stop_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(running) |-> $past(bit_tick));
endmodule

bind atx_serial_tx atx_serial_tx_chk #(.NSLOT_MAX(NSLOT_MAX)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_tick (bit_tick),
  .en_stb   (en_stb),
  .running  (running),
  .sdata    (sdata),
  .fsync    (fsync),
  .uflow    (uflow)
);

// File: tb/test_atx_serial_tx.sv
module test_atx_serial_tx;
  logic        clk = 1'b0, rst_n = 1'b0, bit_tick = 1'b0;
  logic        en_stb = 1'b0, dis_stb = 1'b0, s_valid = 1'b0;
  logic [12:0] cfg_i = '0;
  logic [31:0] s_data = '0;
  logic        s_ready, sdata, fsync, running;
  logic [7:0]  uflow;

  int n_chk = 0, n_fail = 0, uf_cnt = 0;
  logic [31:0] exp_q[$];
  logic [31:0] mirror [8];

  atx_serial_tx i_atx_serial_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .cfg_i(cfg_i),
    .en_stb(en_stb), .dis_stb(dis_stb), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .sdata(sdata), .fsync(fsync), .running(running),
    .uflow(uflow));

  always #4 clk = ~clk;

  always @(negedge clk) if (rst_n) uf_cnt += $countones(uflow);

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int f_len(input int c);
    case (c) 0: return 32; 1: return 24; 2: return 20; 3: return 18;
      4, 5: return 16; default: return 8; endcase
  endfunction

  function automatic int f_slot(input int c, input bit s24);
    if (c == 0) return 32;
    if (c <= 3) return s24 ? 24 : 32;
    if (c <= 5) return 16;
    return 8;
  endfunction

  function automatic logic [12:0] mk(input int fmt, input int len, input bit s24,
      input int nm1, input int fsm, input bit mono, input bit fill);
    return {fill, mono, 2'(fsm), 3'(nm1), s24, 3'(len), 2'(fmt)};
  endfunction

  function automatic logic [31:0] wgen(input logic [31:0] seed, input int i);
    return seed ^ (32'(i + 1) * 32'h9E37_79B9);
  endfunction

  // expected frame-sync level for a bit position, from R2/R3
  function automatic bit exp_fs(input int fmt, input int fsm, input int pos,
                                input int fl, input int sw);
    int q, w;
    q = (fmt == 0 || fmt == 2) ? ((pos + 1) % fl) : pos;
    if (fmt == 0) return q >= fl / 2;
    if (fmt == 1) return q < fl / 2;
    w = (fsm == 0) ? sw : (fsm == 1) ? fl / 2 : 1;
    return q < w;
  endfunction

  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    s_valid = 1'b1;
    s_data  = w;
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic run_case(input logic [12:0] cfg, input int nfr, input int nfed,
                          input logic [31:0] seed, input string dreq,
                          input string freq, input bit chk_ready);
    int fmt, len, fsm, ns, sw, L, fl, fed, exp_uf, uf0;
    bit mono, fill;
    logic [31:0] e, acc, pat;
    logic [63:0] lmask;
    fmt  = int'(cfg[1:0]);  len = int'(cfg[4:2]);
    fsm  = int'(cfg[10:9]); mono = cfg[11]; fill = cfg[12];
    ns   = (fmt >= 2) ? int'(cfg[8:6]) + 1 : 2;
    sw   = f_slot(len, cfg[5]);
    L    = f_len(len);
    fl   = ns * sw;
    fed  = 0; exp_uf = 0;
    for (int k = 0; k < nfr * ns; k++) begin
      int s = k % ns;
      if (mono && (s % 2 == 1)) e = mirror[s - 1];
      else if (fed < nfed) begin e = wgen(seed, fed); fed++; end
      else begin e = fill ? mirror[s] : 32'h0; exp_uf++; end
      mirror[s] = e;
      exp_q.push_back(e);
    end
    uf0 = uf_cnt;
    fork
      for (int i = 0; i < nfed; i++) push_word(wgen(seed, i));
    join_none
    repeat (3) @(negedge clk);
    if (chk_ready) check(s_ready == 1'b0, "R9", "s_ready while word held", s_ready, 0);
    en_stb = 1'b1; cfg_i = cfg;
    @(negedge clk);
    en_stb = 1'b0; cfg_i = ~cfg;   // later changes must be ignored (R8)
    check(running == 1'b1, "R7", "running after enable", running, 1);
    lmask = (64'd1 << L) - 64'd1;
    acc = '0;
    for (int fr = 0; fr < nfr; fr++) begin
      for (int p = 0; p < fl; p++) begin
        do @(posedge clk); while (!bit_tick);
        @(negedge clk);
        if (fr == nfr - 1 && p == 0) dis_stb = 1'b1;
        if (fr == nfr - 1 && p == 1) dis_stb = 1'b0;
        check(fsync == exp_fs(fmt, fsm, p, fl, sw), freq, "fsync level",
              fsync, exp_fs(fmt, fsm, p, fl, sw));
        acc = {acc[30:0], sdata};
        if (p % sw == sw - 1) begin
          e   = exp_q.pop_front();
          pat = 32'((64'(e) & lmask) << (sw - L));
          check(acc == pat, dreq, "slot bits", acc, pat);
          acc = '0;
        end
      end
    end
    check(running == 1'b1, "R7", "running through last bit", running, 1);
    do @(posedge clk); while (!bit_tick);
    @(negedge clk);
    check(running == 1'b0 && sdata == 1'b0 && fsync == 1'b0, "R7",
          "stopped after frame end", {running, sdata, fsync}, 0);
    check(uf_cnt - uf0 == exp_uf, "R6", "underrun pulse count", uf_cnt - uf0, exp_uf);
    repeat (6) @(negedge clk);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin : ticker
    wait (rst_n);
    forever begin
      repeat (3) @(negedge clk);
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  end

  initial begin : main
    int f0;
    for (int i = 0; i < 8; i++) mirror[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(running == 0 && sdata == 0 && fsync == 0 && uflow == 0 && s_ready == 1,
          "R1", "reset state", {running, sdata, fsync, s_ready, uflow}, 13'h100);
    // R9 / R2: I2S, 16-bit
    run_case(mk(0, 4, 0, 0, 0, 0, 0), 2, 4, 32'hA5A5_0F0F, "R9", "R2", 1'b1);
    // R4 / R2 / R8: left-justified, 24-bit in 24-bit slots
    f0 = n_fail;
    run_case(mk(1, 1, 1, 0, 0, 0, 0), 2, 4, 32'h1234_5678, "R4", "R2", 1'b0);
    check(n_fail == f0, "R8", "output unaffected by cfg_i change", n_fail - f0, 0);
    // R3 / R4: 8-slot TDM, 32-bit, one-bit sync
    run_case(mk(2, 0, 0, 7, 2, 0, 0), 2, 16, 32'hDEAD_BEEF, "R4", "R3", 1'b0);
    // R3 / R4: 3-slot aligned TDM, 8-bit, slot-wide sync
    run_case(mk(3, 6, 0, 2, 0, 0, 0), 2, 6, 32'h0BAD_F00D, "R4", "R3", 1'b0);
    // R5 / R3: 4-slot TDM mono, 20-bit in 32-bit slots, half-frame sync
    run_case(mk(2, 2, 0, 3, 1, 1, 0), 2, 4, 32'hC0FF_EE00, "R5", "R3", 1'b0);
    // R6: I2S 18-bit in 24-bit slots, second frame starved, zero fill
    run_case(mk(0, 3, 1, 0, 0, 0, 0), 2, 2, 32'h5555_AAAA, "R6", "R2", 1'b0);
    // R6: left-justified 16-bit compact, starved, repeat previous
    run_case(mk(1, 5, 0, 0, 0, 0, 1), 2, 2, 32'h7777_1111, "R6", "R2", 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule